// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracker

This block follows a single data transfer. It keeps a down-counting byte count and an up-counting bus address. Both registers move together, by one, and only when the data path reports that a byte has been committed. A byte that has only been fetched ahead of time changes neither of them, so the address always names the next byte that will actually be moved.

Software or a sequencer loads the count and the address one byte at a time through an 8-bit register port. The same port reads them back. A clear input zeroes the count. Two status outputs report the state of the count: a done flag that is high whenever the count is zero, and a sticky wrap flag. The wrap flag sets when a commit arrives while the count is already zero.

Top module: `xfer_byte_tracker`

## Requirements
- R1: After reset the count is 0, the address is 0, done is 1 and wrap is 0.
- R2: The register port writes and reads single bytes, least significant byte at the lowest offset. Offsets 0..2 hold the 24-bit count and offsets 4..7 hold the 32-bit address. A write takes effect on the next clock edge, and a read returns the stored value combinationally.
- R3: A commit pulse, with no load and no clear in the same cycle, decrements the count by one and increments the address by one on the same clock edge.
- R4: In a cycle with no commit, no load and no clear, the count, the address and both flags hold their values.
- R5: Done is high exactly when the stored count is zero, and it updates on the same edge as the count. Loading a byte that makes the count nonzero drops done on that edge.
- R6: A commit while the count is zero rolls the count to 0xFFFFFF, sets wrap and still advances the address.
- R7: Wrap stays set until a count byte is written or a clear is applied. Both of those drop it.
- R8: Clear zeroes the count, sets done and drops wrap, and leaves the address as it was. In a clear cycle, register writes and commits are ignored.
- R9: When a count or address byte write and a commit fall in the same cycle, the write takes effect and the commit is dropped. Neither the count nor the address steps.
- R10: Offset 3 reads as status: bit 0 is done, bit 1 is wrap, and the upper bits are 0. A write to offset 3 changes nothing and does not block a commit in the same cycle.
- R11: The address wraps from 0xFFFFFFFF to 0 on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_off_i | input | 3 | Register write offset |
| wr_data_i | input | 8 | Register write data |
| rd_off_i | input | 3 | Register read offset |
| rd_data_o | output | 8 | Register read data (combinational) |
| commit_i | input | 1 | One byte has been transferred and committed |
| clr_cnt_i | input | 1 | Clear the byte count |
| done_o | output | 1 | Count is zero |
| wrap_o | output | 1 | Count underflowed since the last load or clear |

## Verification
A register load, a commit and a clear can all land on the same edge. The main contest is a byte load against a commit, with the clear ranked above both. The bench drives every combination of write enable, commit and clear against every register offset, including the read-only status offset. After each edge it reads the whole register space back and compares it with an arithmetic model that applies the order clear, then load, then commit. A lost load, an address that steps while a count byte is being written, or a commit that is blocked by a status write all show up as a mismatch in count, address or status.

// File: rtl/xfer_trk_pkg.sv
`timescale 1ns/1ps
package xfer_trk_pkg;
  localparam int REG_DW        = 8;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_WRAP_BIT = 1;
endpackage

// File: rtl/xfer_op_decode.sv
`timescale 1ns/1ps
module xfer_op_decode #(
  parameter int CNT_BYTES  = 3,
  parameter int ADDR_BYTES = 4,
  parameter int OFF_W      = 3
) (
  input  logic                  wr_en_i,
  input  logic [OFF_W-1:0]      wr_off_i,
  input  logic                  commit_i,
  input  logic                  clr_i,
  output logic [CNT_BYTES-1:0]  cnt_be_o,
  output logic [ADDR_BYTES-1:0] adr_be_o,
  output logic                  step_o
);
  localparam int ADDR_BASE = CNT_BYTES + 1;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt_be
    assign cnt_be_o[b] = wr_en_i & ~clr_i & (wr_off_i == OFF_W'(b));
  end
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_adr_be
    assign adr_be_o[b] = wr_en_i & ~clr_i & (wr_off_i == OFF_W'(ADDR_BASE + b));
  end

  // priority: clear, then load, then commit
  assign step_o = commit_i & ~clr_i & ~(|cnt_be_o) & ~(|adr_be_o);
endmodule

// File: rtl/xfer_down_cnt.sv
`timescale 1ns/1ps
module xfer_down_cnt
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int NB   = CNT_W / REG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [NB-1:0]     be_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              step_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic              wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, loaded;
  logic             wrap_q, wrap_d, done_q;

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign loaded[b*REG_DW +: REG_DW] = be_i[b] ? wdata_i : cnt_q[b*REG_DW +: REG_DW];
  end

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = wrap_q;
    if (clr_i) begin
      cnt_d  = '0;
      wrap_d = 1'b0;
    end else if (|be_i) begin
      cnt_d  = loaded;
      wrap_d = 1'b0;
    end else if (step_i) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == '0) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      done_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      done_q <= (cnt_d == '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/xfer_up_addr.sv
`timescale 1ns/1ps
module xfer_up_addr
  import xfer_trk_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int NB    = ADDR_W / REG_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     be_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, loaded;

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign loaded[b*REG_DW +: REG_DW] = be_i[b] ? wdata_i : addr_q[b*REG_DW +: REG_DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (|be_i)     addr_q <= loaded;
    else if (step_i)    addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/xfer_rd_mux.sv
`timescale 1ns/1ps
module xfer_rd_mux
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3
) (
  input  logic [OFF_W-1:0]  rd_off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              done_i,
  input  logic              wrap_i,
  output logic [REG_DW-1:0] rd_data_o
);
  localparam int CNT_BYTES  = CNT_W / REG_DW;
  localparam int ADDR_BYTES = ADDR_W / REG_DW;
  localparam int ADDR_BASE  = CNT_BYTES + 1;

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < CNT_BYTES; b++)
      if (rd_off_i == OFF_W'(b)) rd_data_o = cnt_i[b*REG_DW +: REG_DW];
    if (rd_off_i == OFF_W'(CNT_BYTES)) begin
      rd_data_o[STAT_DONE_BIT] = done_i;
      rd_data_o[STAT_WRAP_BIT] = wrap_i;
    end
    for (int b = 0; b < ADDR_BYTES; b++)
      if (rd_off_i == OFF_W'(ADDR_BASE + b)) rd_data_o = addr_i[b*REG_DW +: REG_DW];
  end
endmodule

// File: rtl/xfer_byte_tracker.sv
`timescale 1ns/1ps
module xfer_byte_tracker
  import xfer_trk_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 32,
  localparam int CNT_BYTES  = CNT_W / REG_DW,
  localparam int ADDR_BYTES = ADDR_W / REG_DW,
  localparam int OFF_W      = $clog2(CNT_BYTES + 1 + ADDR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [REG_DW-1:0] rd_data_o,
  input  logic              commit_i,
  input  logic              clr_cnt_i,
  output logic              done_o,
  output logic              wrap_o
);
  logic [CNT_BYTES-1:0]  cnt_be;
  logic [ADDR_BYTES-1:0] adr_be;
  logic                  step;
  logic [CNT_W-1:0]      cnt_q;
  logic [ADDR_W-1:0]     addr_q;

  xfer_op_decode #(.CNT_BYTES(CNT_BYTES), .ADDR_BYTES(ADDR_BYTES), .OFF_W(OFF_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_off_i (wr_off_i),
    .commit_i (commit_i),
    .clr_i    (clr_cnt_i),
    .cnt_be_o (cnt_be),
    .adr_be_o (adr_be),
    .step_o   (step)
  );

  xfer_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_cnt_i),
    .be_i    (cnt_be),
    .wdata_i (wr_data_i),
    .step_i  (step),
    .cnt_o   (cnt_q),
    .done_o  (done_o),
    .wrap_o  (wrap_o)
  );

  xfer_up_addr #(.ADDR_W(ADDR_W)) u_adr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .be_i    (adr_be),
    .wdata_i (wr_data_i),
    .step_i  (step),
    .addr_o  (addr_q)
  );

  xfer_rd_mux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rd (
    .rd_off_i  (rd_off_i),
    .cnt_i     (cnt_q),
    .addr_i    (addr_q),
    .done_i    (done_o),
    .wrap_i    (wrap_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/xfer_byte_tracker_chk.sv
`timescale 1ns/1ps
module xfer_byte_tracker_chk #(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 32,
  localparam int CNT_BYTES  = CNT_W / 8,
  localparam int ADDR_BYTES = ADDR_W / 8,
  localparam int ADDR_BASE  = CNT_BYTES + 1,
  localparam int OFF_W      = $clog2(CNT_BYTES + 1 + ADDR_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [OFF_W-1:0]  wr_off_i,
  input logic              commit_i,
  input logic              clr_cnt_i,
  input logic              done_o,
  input logic              wrap_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [ADDR_W-1:0] addr_i
);
  logic cnt_ld, adr_ld, any_ld, plain_step;
  assign cnt_ld = wr_en_i && (int'(wr_off_i) < CNT_BYTES);
  assign adr_ld = wr_en_i && (int'(wr_off_i) >= ADDR_BASE) && (int'(wr_off_i) < ADDR_BASE + ADDR_BYTES);
  assign any_ld = cnt_ld || adr_ld;
  assign plain_step = commit_i && !any_ld && !clr_cnt_i;

  // R3
  commit_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_step |=> (cnt_i == $past(cnt_i) - 1'b1) && (addr_i == $past(addr_i) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !any_ld && !clr_cnt_i) |=> $stable(cnt_i) && $stable(addr_i) && $stable(wrap_o));

  // R5
  done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (cnt_i == '0));

  // R6
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain_step && cnt_i == '0) |=> wrap_o && (cnt_i == '1));

  // R7
  wrap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !clr_cnt_i && !cnt_ld) |=> wrap_o);

  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cnt_i |=> (cnt_i == '0) && !wrap_o && done_o && $stable(addr_i));

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ld && commit_i && !clr_cnt_i) |=> $stable(addr_i));
endmodule

bind xfer_byte_tracker xfer_byte_tracker_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_off_i  (wr_off_i),
  .commit_i  (commit_i),
  .clr_cnt_i (clr_cnt_i),
  .done_o    (done_o),
  .wrap_o    (wrap_o),
  .cnt_i     (cnt_q),
  .addr_i    (addr_q)
);

// File: tb/tb_xfer_byte_tracker.sv
`timescale 1ns/1ps
module tb_xfer_byte_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_off_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_off_i = '0;
  logic [7:0] rd_data_o;
  logic       commit_i = 1'b0;
  logic       clr_cnt_i = 1'b0;
  logic       done_o, wrap_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [23:0] m_cnt = '0;
  logic [31:0] m_adr = '0;
  logic        m_wrap = 1'b0;

  always #2.5 clk_i = ~clk_i;

  xfer_byte_tracker dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_off_i, .wr_data_i,
    .rd_off_i, .rd_data_o, .commit_i, .clr_cnt_i, .done_o, .wrap_o
  );

  task automatic expect32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] off, output logic [7:0] d);
    rd_off_i = off;
    #0.2;
    d = rd_data_o;
  endtask

  // reads the whole register space and compares it with the model
  task automatic check_all(input string tag);
    logic [7:0]  b;
    logic [23:0] c;
    logic [31:0] a;
    for (int i = 0; i < 3; i++) begin rd(3'(i), b); c[i*8 +: 8] = b; end
    for (int i = 0; i < 4; i++) begin rd(3'(4 + i), b); a[i*8 +: 8] = b; end
    expect32(tag, "count", {8'h0, c}, {8'h0, m_cnt});
    expect32(tag, "address", a, m_adr);
    rd(3'd3, b);
    expect32(tag, "status", {24'h0, b}, {30'h0, m_wrap, (m_cnt == 24'h0)});
    expect32(tag, "done pin", {31'h0, done_o}, {31'h0, (m_cnt == 24'h0)});
    expect32(tag, "wrap pin", {31'h0, wrap_o}, {31'h0, m_wrap});
  endtask

  // one clock with the given inputs; model applies clear > load > commit
  task automatic step(input logic we, input logic [2:0] off, input logic [7:0] d,
                      input logic cm, input logic cl, input string tag);
    @(negedge clk_i);
    wr_en_i = we; wr_off_i = off; wr_data_i = d; commit_i = cm; clr_cnt_i = cl;
    @(posedge clk_i);
    #0.3;
    wr_en_i = 1'b0; commit_i = 1'b0; clr_cnt_i = 1'b0;
    if (cl) begin
      m_cnt = '0; m_wrap = 1'b0;
    end else if (we && off < 3'd3) begin
      m_cnt[off*8 +: 8] = d; m_wrap = 1'b0;
    end else if (we && off > 3'd3) begin
      m_adr[(off-4)*8 +: 8] = d;
    end else if (cm) begin
      if (m_cnt == 24'h0) m_wrap = 1'b1;
      m_cnt = m_cnt - 24'h1;
      m_adr = m_adr + 32'h1;
    end
    check_all(tag);
  endtask

  task automatic load_all(input logic [23:0] c, input logic [31:0] a, input string tag);
    for (int i = 0; i < 3; i++) step(1'b1, 3'(i), c[i*8 +: 8], 1'b0, 1'b0, tag);
    for (int i = 0; i < 4; i++) step(1'b1, 3'(4 + i), a[i*8 +: 8], 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12 rst_ni = 1'b1;
    #1;
    check_all("R1");

    // R2 byte-wise load and readback
    load_all(24'h000003, 32'h1000_00FE, "R2");

    // R3 commits down to zero, R5 done rises at zero
    for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, (i == 2) ? "R5" : "R3");
    // R4 idle cycles hold
    for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 8'h0, 1'b0, 1'b0, "R4");
    // R6 commit at zero rolls and sets wrap
    step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R6");
    // R7 wrap sticky across further commits and address writes
    step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R7");
    step(1'b1, 3'd5, 8'h22, 1'b0, 1'b0, "R7");
    // R7 count write drops wrap; R5 nonzero load drops done
    step(1'b1, 3'd0, 8'h05, 1'b0, 1'b0, "R7");
    step(1'b1, 3'd2, 8'h00, 1'b0, 1'b0, "R5");
    step(1'b1, 3'd1, 8'h00, 1'b0, 1'b0, "R5");
    // R10 status write ignored and commit still happens
    step(1'b1, 3'd3, 8'hFF, 1'b1, 1'b0, "R10");
    // R9 load beats commit
    step(1'b1, 3'd0, 8'h09, 1'b1, 1'b0, "R9");
    step(1'b1, 3'd6, 8'h44, 1'b1, 1'b0, "R9");
    // R8 clear beats load and commit
    step(1'b1, 3'd0, 8'h77, 1'b1, 1'b1, "R8");

    // sweep all control combinations against every offset
    for (int combo = 0; combo < 8; combo++) begin
      for (int off = 0; off < 8; off++) begin
        logic we, cm, cl;
        string tag;
        we = combo[0]; cm = combo[1]; cl = combo[2];
        if (cl) tag = "R8";
        else if (we && off != 3 && cm) tag = "R9";
        else if (we && off == 3) tag = "R10";
        else if (we) tag = "R2";
        else if (cm) tag = "R3";
        else tag = "R4";
        step(we, 3'(off), 8'(combo * 5 + off * 3 + 1), cm, cl, tag);
        if (off == 4) step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R6");
      end
    end

    // R11 address wraps at the top
    load_all(24'h000002, 32'hFFFF_FFFF, "R2");
    step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R11");
    step(1'b0, 3'd0, 8'h0, 1'b1, 1'b0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule